// File: doc/BRIEF.md
# Asymmetric Overcurrent Fault Timer

This block guards one powered port against sustained overcurrent. It owns the port's on/off state, and its `port_on` output drives the gate of the external switch. An analog comparator supplies a flag that is high while the port current sits above the cut threshold. While the port is on and that flag is high, a fault integrator counts up once per time-base tick. When the count reaches its limit, the port is switched off and a fault is reported. Two limits are supplied: a short one that applies while the startup-window flag is high, and a longer one for steady-state overload.

Once the current is back below the threshold, or the port is off, the count decays. The decay rate is sixteen times slower than the rise, so repeated short overloads still add up to a trip. A request to switch the port on is honoured only when the count has fully drained to zero. Earlier requests are dropped, and a one-cycle reject pulse reports each dropped request. Current limiting and foldback happen in the analog domain and are not part of this block.

There is no data stream, so every pin is a plain level or pulse sampled on the rising clock edge. Nothing is buffered and there is no back-pressure.

Top module: `ocp_fault_timer`

## Requirements
- R1: While `port_on` is 1 and `over_cut` is 1, each cycle with `tick` high raises `count` by exactly one. A cycle with `tick` low leaves `count` and the decay prescaler unchanged.
- R2: The trip limit is `lim_start` while `start_win` is 1 and `lim_ovld` while it is 0. A trip happens on the tick that brings `count` to the limit, and never earlier.
- R3: On the trip edge, `port_on` falls to 0 and `fault_pulse` is high for exactly one cycle.
- R4: On a tick where the count is not rising, a nonzero count drops by one on every sixteenth such tick. The first drop comes on the sixteenth tick. Any rising tick restarts the sixteen-tick spacing.
- R5: The count never goes below zero. Decay ticks at zero leave it at zero.
- R6: `on_req` while `count` is zero sets `port_on` to 1 on the next edge.
- R7: `on_req` while `count` is nonzero leaves `port_on` at 0 and raises `reject_pulse` for one cycle.
- R8: `fault_sticky` is set by a trip and stays set until a cycle with `flt_clr` high. A trip in the same cycle as the clear wins.
- R9: After reset, `port_on`, `count`, `fault_pulse`, `fault_sticky` and `reject_pulse` are all 0. `off_req` drops `port_on` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base enable for the integrator |
| over_cut | input | 1 | Port current above cut threshold |
| start_win | input | 1 | Port is inside its startup window |
| on_req | input | 1 | Request to switch the port on |
| off_req | input | 1 | Request to switch the port off |
| flt_clr | input | 1 | Clears the sticky fault bit |
| lim_start | input | CNT_W | Trip limit during startup |
| lim_ovld | input | CNT_W | Trip limit in steady state |
| port_on | output | 1 | Port state / gate enable |
| count | output | CNT_W | Fault integrator value |
| fault_pulse | output | 1 | One-cycle trip indication |
| fault_sticky | output | 1 | Latched fault status |
| reject_pulse | output | 1 | One-cycle refused power-on request |

## Verification
The bench sweeps small limits in both phases and checks several points:
- It checks the count one tick before the limit. A comparator off by one would trip early.
- It checks the count on the fifteenth and sixteenth decay ticks. A prescaler off by one, or one that is not cleared on a rising tick, would move the step.
- It fires a power-on request halfway through decay. A design that tested `port_on` instead of the count would re-power a hot switch.
- It checks that decay ticks at zero leave the count at zero, and that a gapped tick freezes the count.

// File: rtl/oft_pkg.sv
package oft_pkg;
  typedef enum logic [1:0] {
    CA_HOLD = 2'd0,
    CA_UP   = 2'd1,
    CA_DOWN = 2'd2
  } cnt_act_e;
endpackage

// File: rtl/oft_integrator.sv
module oft_integrator
  import oft_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             up,
  input  logic [CNT_W-1:0] lim,
  output logic             trip,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W:0]   next_up;
  cnt_act_e         act;

  assign next_up = {1'b0, count} + {{CNT_W{1'b0}}, 1'b1};
  assign trip    = tick && up && (next_up >= {1'b0, lim});

  always_comb begin
    act = CA_HOLD;
    if (tick) begin
      if (up)
        act = CA_UP;
      else if (count != '0 && pre_q == PRE_MAX)
        act = CA_DOWN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      pre_q <= '0;
    end else begin
      unique case (act)
        CA_UP:   if (count != CNT_MAX) count <= count + 1'b1;
        CA_DOWN: count <= count - 1'b1;
        default: count <= count;
      endcase
      if (tick) begin
        if (up || count == '0)
          pre_q <= '0;
        else
          pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/oft_port_ctl.sv
module oft_port_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  input  logic cnt_zero,
  input  logic on_req,
  input  logic off_req,
  input  logic flt_clr,
  output logic port_on,
  output logic fault_pulse,
  output logic fault_sticky,
  output logic reject_pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_on      <= 1'b0;
      fault_pulse  <= 1'b0;
      fault_sticky <= 1'b0;
      reject_pulse <= 1'b0;
    end else begin
      fault_pulse  <= trip;
      reject_pulse <= on_req && !cnt_zero;
      if (trip || off_req)
        port_on <= 1'b0;
      else if (on_req && cnt_zero)
        port_on <= 1'b1;
      if (trip)
        fault_sticky <= 1'b1;
      else if (flt_clr)
        fault_sticky <= 1'b0;
    end
  end
endmodule

// File: rtl/ocp_fault_timer.sv
module ocp_fault_timer #(
  parameter int CNT_W = 10,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             over_cut,
  input  logic             start_win,
  input  logic             on_req,
  input  logic             off_req,
  input  logic             flt_clr,
  input  logic [CNT_W-1:0] lim_start,
  input  logic [CNT_W-1:0] lim_ovld,
  output logic             port_on,
  output logic [CNT_W-1:0] count,
  output logic             fault_pulse,
  output logic             fault_sticky,
  output logic             reject_pulse
);
  logic             rising;
  logic             trip;
  logic [CNT_W-1:0] lim_sel;

  assign rising  = port_on && over_cut;
  assign lim_sel = start_win ? lim_start : lim_ovld;

  oft_integrator #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_int (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .up    (rising),
    .lim   (lim_sel),
    .trip  (trip),
    .count (count)
  );

  oft_port_ctl u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .trip         (trip),
    .cnt_zero     (count == '0),
    .on_req       (on_req),
    .off_req      (off_req),
    .flt_clr      (flt_clr),
    .port_on      (port_on),
    .fault_pulse  (fault_pulse),
    .fault_sticky (fault_sticky),
    .reject_pulse (reject_pulse)
  );
endmodule

// File: rtl/oft_checker.sv
module oft_checker #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             over_cut,
  input logic             on_req,
  input logic             port_on,
  input logic [CNT_W-1:0] count,
  input logic             fault_pulse,
  input logic             reject_pulse
);
  a_r1_rise_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (count > $past(count)) |-> ($past(tick) && $past(port_on) && $past(over_cut)));

  a_r3_trip_turns_off: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> !port_on);

  a_r3_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |=> !fault_pulse);

  a_r4_decay_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (count < $past(count)) |-> ($past(count) - count == 1));

  a_r6_on_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_on) |-> ($past(count) == '0 && $past(on_req)));

  a_r7_reject_cause: assert property (@(posedge clk) disable iff (!rst_n)
    reject_pulse |-> ($past(on_req) && $past(count) != '0));
endmodule

bind ocp_fault_timer oft_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick         (tick),
  .over_cut     (over_cut),
  .on_req       (on_req),
  .port_on      (port_on),
  .count        (count),
  .fault_pulse  (fault_pulse),
  .reject_pulse (reject_pulse)
);

// File: tb/sim_ocp_fault_timer.sv
module sim_ocp_fault_timer;
  localparam int CLK_NS = 10;
  localparam int CW = 10;
  localparam int DECAY = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, over_cut = 1'b0, start_win = 1'b0;
  logic on_req = 1'b0, off_req = 1'b0, flt_clr = 1'b0;
  logic [CW-1:0] lim_start = '0, lim_ovld = '0;
  logic port_on, fault_pulse, fault_sticky, reject_pulse;
  logic [CW-1:0] count;
  int total = 0, bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  ocp_fault_timer #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .over_cut(over_cut),
    .start_win(start_win), .on_req(on_req), .off_req(off_req),
    .flt_clr(flt_clr), .lim_start(lim_start), .lim_ovld(lim_ovld),
    .port_on(port_on), .count(count), .fault_pulse(fault_pulse),
    .fault_sticky(fault_sticky), .reject_pulse(reject_pulse));

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic power_on();
    on_req = 1'b1;
    step();
    on_req = 1'b0;
    chk("R6 on accepted", port_on, 1);
  endtask

  task automatic run_case(int lim, bit st);
    start_win = st;
    lim_start = CW'(lim);
    lim_ovld  = CW'(lim + 3);
    begin
      int eff = st ? lim : lim + 3;
      power_on();
      tick = 1'b1;
      over_cut = 1'b1;
      for (int k = 1; k < eff; k++) step();
      chk("R1 count before limit", count, eff - 1);
      chk("R2 no early trip", port_on, 1);
      step();
      chk("R2 count at trip", count, eff);
      chk("R3 port off on trip", port_on, 0);
      chk("R3 fault pulse", fault_pulse, 1);
      chk("R8 sticky set", fault_sticky, 1);
      over_cut = 1'b0;
      for (int e = 1; e <= eff * DECAY; e++) begin
        if (e == 8) on_req = 1'b1;
        step();
        on_req = 1'b0;
        if (e == 1) chk("R3 pulse one cycle", fault_pulse, 0);
        if (e == 8) begin
          chk("R7 reject pulse", reject_pulse, 1);
          chk("R7 port stays off", port_on, 0);
        end
        if (e == 9) chk("R7 reject one cycle", reject_pulse, 0);
        if (e == DECAY - 1) chk("R4 no step at 15", count, eff);
        if (e % DECAY == 0) chk("R4 decay step", count, eff - e / DECAY);
      end
      for (int z = 0; z < 20; z++) step();
      chk("R5 stays at zero", count, 0);
      flt_clr = 1'b1;
      step();
      flt_clr = 1'b0;
      chk("R8 sticky cleared", fault_sticky, 0);
    end
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    step();
    step();
    chk("R9 reset port_on", port_on, 0);
    chk("R9 reset count", count, 0);
    chk("R9 reset sticky", fault_sticky, 0);
    chk("R9 reset pulses", {fault_pulse, reject_pulse}, 0);
    rst_n = 1'b1;
    step();

    for (int l = 1; l <= 6; l++) begin
      run_case(l, 1'b1);
      run_case(l, 1'b0);
    end

    // R1: tick gap freezes count; R4: rising tick restarts spacing
    start_win = 1'b0;
    lim_ovld = CW'(50);
    power_on();
    tick = 1'b1;
    over_cut = 1'b1;
    step(); step(); step();
    chk("R1 three ticks", count, 3);
    tick = 1'b0;
    step(); step();
    chk("R1 gap holds count", count, 3);
    tick = 1'b1;
    over_cut = 1'b0;
    for (int i = 0; i < 10; i++) step();
    over_cut = 1'b1;
    step();
    chk("R1 rise after partial decay", count, 4);
    over_cut = 1'b0;
    for (int i = 0; i < 15; i++) step();
    chk("R4 spacing restarted", count, 4);
    step();
    chk("R4 step after restart", count, 3);
    // R9: off request
    off_req = 1'b1;
    step();
    off_req = 1'b0;
    chk("R9 off request", port_on, 0);
    for (int i = 0; i < 3 * DECAY; i++) step();
    chk("R5 drained", count, 0);
    // R8: trip coincident with clear keeps sticky set
    lim_ovld = CW'(2);
    power_on();
    over_cut = 1'b1;
    step();
    flt_clr = 1'b1;
    step();
    flt_clr = 1'b0;
    chk("R8 trip beats clear", fault_sticky, 1);
    over_cut = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule